// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Self-Refresh

This block decides when a dynamic memory array must be refreshed and drives the refresh strobes itself. An interval timer raises a refresh request towards the access sequencer. The sequencer answers with a grant between its own accesses. Once granted, the block takes over the row strobe and both column strobes and runs a CAS-before-RAS cycle: both column strobes go low first, then the row strobe follows. The row address comes from the memory's internal counter. When the block is not busy, the sequencer's strobes pass straight through to the memory pins.

A low-power request asks the block to put the memory into self-refresh, and a wake request takes it out again. Entry is a normal CBR refresh followed directly by a CBR cycle whose row strobe is held low for at least the self-refresh hold time. Exit is a long self-refresh precharge followed directly by one more CBR refresh. A sweep tracker counts the CBR cycles issued since the last self-refresh exit. It holds off further low-power requests until every row has been refreshed again. All timing values are parameters counted in clock cycles.

Top module: `refresh_sched`

## Requirements
- R1: While `busy` is low, the three memory strobes equal the sequencer's strobes. While `busy` is high, the block drives them itself. `busy` rises only in the cycle after `ref_req` and `ref_gnt` were both high.
- R2: `ref_req` rises about INTERVAL cycles after reset or after the last refresh ended. It stays high without a grant, and `busy` stays low in that time.
- R3: In every refresh, both column strobes are low for at least TCSR cycles before the row strobe falls. A normal refresh holds the row strobe low for exactly TRAS cycles. The row strobe is then high for at least TRP cycles before it falls again.
- R4: Outside self-refresh, when the grant latency stays below one interval, consecutive refresh row-strobe falls are at most 2*INTERVAL cycles apart.
- R5: `status[0]` is the sweep-complete flag. It is 0 after reset, becomes 1 once ROWS CBR refreshes have completed since reset or since the last self-refresh exit, and clears when self-refresh is left.
- R6: `lp_req` has no effect until `status[0]` is 1. Self-refresh never starts with fewer than ROWS refreshes since the last exit.
- R7: Self-refresh entry is a normal CBR refresh followed, with `busy` kept high, by a row-strobe high time of exactly TRP+TCSR cycles. The self-refresh low period comes next.
- R8: `status[1]` is high while the memory is in self-refresh, with all strobes low. The row strobe stays low for at least SR_HOLD cycles, even if `wake_req` is already high. No row-strobe low period lasts from SR_FORBID up to SR_HOLD-1 cycles.
- R9: After `wake_req`, the row strobe is high for exactly TRPS+TCSR cycles before the post-exit CBR refresh. After that refresh, `busy` drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_ras_n | input | 1 | Row strobe from the access sequencer |
| seq_ucas_n | input | 1 | Upper column strobe from the access sequencer |
| seq_lcas_n | input | 1 | Lower column strobe from the access sequencer |
| ref_gnt | input | 1 | Grant from the access sequencer |
| lp_req | input | 1 | Low-power (self-refresh) request, level |
| wake_req | input | 1 | Leave self-refresh request, level |
| ref_req | output | 1 | Request for the memory bus |
| busy | output | 1 | Block owns the memory strobes |
| dram_ras_n | output | 1 | Row strobe to the memory |
| dram_ucas_n | output | 1 | Upper column strobe to the memory |
| dram_lcas_n | output | 1 | Lower column strobe to the memory |
| status | output | 2 | bit 0 sweep complete, bit 1 in self-refresh |

## Verification
The bench holds the grant back for varying delays. A timer that restarts from the wrong event, or that loses a pending request, then shows up as a refresh gap longer than two intervals. It asserts `wake_req` in the first cycle of self-refresh. A design that honours wake early would release the row strobe inside the forbidden window, and the measured low period would fall short of SR_HOLD. It keeps `lp_req` high from the start and again right after an exit. A tracker that does not clear on exit, or that ignores it, would start self-refresh before a full sweep. It also measures the high times around entry and exit exactly. A short precharge after self-refresh, or a missing bracket refresh, changes those counts.

// File: rtl/refsch_pkg.sv
package refsch_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_CSR, ST_RASLO, ST_PRE, ST_SRHOLD, ST_SRPRE
   } st_e;

   typedef enum logic [1:0] {
      MD_NORM, MD_ENTRY, MD_SRIN, MD_EXIT
   } md_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/refsch_timer.sv
module refsch_timer #(
   parameter int unsigned INTERVAL = 1560
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic due
);
   localparam int unsigned CW = $clog2(INTERVAL + 1);
   localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         due <= 1'b0;
      end else if (restart) begin
         cnt <= '0;
         due <= 1'b0;
      end else if (cnt == LAST) begin
         due <= 1'b1;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/refsch_sweep.sv
module refsch_sweep #(
   parameter int unsigned ROWS = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cbr_done,
   input  logic clear,
   output logic done
);
   generate
      if (ROWS == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        done <= 1'b0;
            else if (clear)    done <= 1'b0;
            else if (cbr_done) done <= 1'b1;
         end
      end else begin : g_count
         localparam int unsigned SW = $clog2(ROWS + 1);
         localparam logic [SW-1:0] FULL = SW'(ROWS);
         logic [SW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       cnt <= '0;
            else if (clear)                   cnt <= '0;
            else if (cbr_done && cnt != FULL) cnt <= cnt + 1'b1;
         end
         assign done = (cnt == FULL);
      end
   endgenerate
endmodule

// File: rtl/refsch_fsm.sv
module refsch_fsm
   import refsch_pkg::*;
#(
   parameter int unsigned TCSR    = 1,
   parameter int unsigned TRAS    = 5,
   parameter int unsigned TRP     = 3,
   parameter int unsigned SR_HOLD = 10000,
   parameter int unsigned TRPS    = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_due,
   input  logic sweep_done,
   input  logic lp_req,
   input  logic wake_req,
   input  logic ref_gnt,
   output logic ref_req,
   output logic busy,
   output logic ras_n,
   output logic cas_n,
   output logic cbr_done,
   output logic sr_exit,
   output logic sr_active
);
   localparam int unsigned MAXLEN = max2(max2(max2(TCSR, TRAS), max2(TRP, TRPS)), SR_HOLD);
   localparam int unsigned PW = $clog2(MAXLEN + 1);
   localparam logic [PW-1:0] L_CSR  = PW'(TCSR - 1);
   localparam logic [PW-1:0] L_RAS  = PW'(TRAS - 1);
   localparam logic [PW-1:0] L_PRE  = PW'(TRP - 1);
   localparam logic [PW-1:0] L_SRP  = PW'(TRPS - 1);
   localparam logic [PW-1:0] L_HOLD = PW'(SR_HOLD - 1);

   st_e           state;
   md_e           mode;
   logic [PW-1:0] ph;
   logic          want_sr;
   logic          hold_ok;

   assign want_sr = lp_req && sweep_done;
   assign ref_req = (state == ST_IDLE) && (ref_due || want_sr);
   assign hold_ok = (ph == L_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         mode  <= MD_NORM;
         ph    <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (ref_req && ref_gnt) begin
               state <= ST_CSR;
               mode  <= want_sr ? MD_ENTRY : MD_NORM;
               ph    <= '0;
            end
            ST_CSR: if (ph == L_CSR) begin
               state <= (mode == MD_SRIN) ? ST_SRHOLD : ST_RASLO;
               ph    <= '0;
            end else ph <= ph + 1'b1;
            ST_RASLO: if (ph == L_RAS) begin
               state <= ST_PRE;
               ph    <= '0;
            end else ph <= ph + 1'b1;
            ST_PRE: if (ph == L_PRE) begin
               ph <= '0;
               if (mode == MD_ENTRY) begin
                  state <= ST_CSR;
                  mode  <= MD_SRIN;
               end else begin
                  state <= ST_IDLE;
               end
            end else ph <= ph + 1'b1;
            ST_SRHOLD: if (hold_ok && wake_req) begin
               state <= ST_SRPRE;
               ph    <= '0;
            end else if (!hold_ok) ph <= ph + 1'b1;
            ST_SRPRE: if (ph == L_SRP) begin
               state <= ST_CSR;
               mode  <= MD_EXIT;
               ph    <= '0;
            end else ph <= ph + 1'b1;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state != ST_IDLE);
   assign sr_active = (state == ST_SRHOLD);
   assign ras_n     = !(state == ST_RASLO || state == ST_SRHOLD);
   assign cas_n     = !(state == ST_CSR || state == ST_RASLO || state == ST_SRHOLD);
   assign cbr_done  = (state == ST_RASLO) && (ph == L_RAS);
   assign sr_exit   = sr_active && hold_ok && wake_req;
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
   parameter int unsigned INTERVAL  = 1560,
   parameter int unsigned ROWS      = 4096,
   parameter int unsigned TCSR      = 1,
   parameter int unsigned TRAS      = 5,
   parameter int unsigned TRP       = 3,
   parameter int unsigned SR_FORBID = 1000,
   parameter int unsigned SR_HOLD   = 10000,
   parameter int unsigned TRPS      = 11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       seq_ras_n,
   input  logic       seq_ucas_n,
   input  logic       seq_lcas_n,
   input  logic       ref_gnt,
   input  logic       lp_req,
   input  logic       wake_req,
   output logic       ref_req,
   output logic       busy,
   output logic       dram_ras_n,
   output logic       dram_ucas_n,
   output logic       dram_lcas_n,
   output logic [1:0] status
);
   generate
      if (TCSR < 1 || TRAS < 1 || TRP < 1 || TRPS < TRP) begin : g_bad_timing
         $error("refresh_sched: strobe timing parameters out of range");
      end
      if (!(TRAS < SR_FORBID && SR_FORBID < SR_HOLD)) begin : g_bad_window
         $error("refresh_sched: need TRAS < SR_FORBID < SR_HOLD");
      end
      if (INTERVAL < 2 || ROWS < 1) begin : g_bad_sched
         $error("refresh_sched: INTERVAL and ROWS out of range");
      end
   endgenerate

   logic due, sweep_done, cbr_done, sr_exit, sr_active;
   logic own_ras_n, own_cas_n;

   refsch_timer #(.INTERVAL(INTERVAL)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(cbr_done), .due(due)
   );

   refsch_sweep #(.ROWS(ROWS)) u_sweep (
      .clk(clk), .rst_n(rst_n), .cbr_done(cbr_done), .clear(sr_exit),
      .done(sweep_done)
   );

   refsch_fsm #(
      .TCSR(TCSR), .TRAS(TRAS), .TRP(TRP), .SR_HOLD(SR_HOLD), .TRPS(TRPS)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .ref_due(due), .sweep_done(sweep_done),
      .lp_req(lp_req), .wake_req(wake_req), .ref_gnt(ref_gnt),
      .ref_req(ref_req), .busy(busy), .ras_n(own_ras_n), .cas_n(own_cas_n),
      .cbr_done(cbr_done), .sr_exit(sr_exit), .sr_active(sr_active)
   );

   assign dram_ras_n  = busy ? own_ras_n : seq_ras_n;
   assign dram_ucas_n = busy ? own_cas_n : seq_ucas_n;
   assign dram_lcas_n = busy ? own_cas_n : seq_lcas_n;
   assign status      = {sr_active, sweep_done};
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
   parameter int unsigned TRAS      = 5,
   parameter int unsigned SR_FORBID = 1000,
   parameter int unsigned SR_HOLD   = 10000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ref_req,
   input logic       ref_gnt,
   input logic       busy,
   input logic       dram_ras_n,
   input logic       dram_ucas_n,
   input logic       dram_lcas_n,
   input logic [1:0] status
);
   logic [31:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           low_run <= '0;
      else if (!dram_ras_n) low_run <= low_run + 1'b1;
      else                  low_run <= '0;
   end

   a_r1_busy_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(ref_req && ref_gnt));

   a_r3_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $fell(dram_ras_n)) |-> $past(!dram_ucas_n && !dram_lcas_n));

   a_r3_ras_low_len: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dram_ras_n) && $past(busy)) |-> (low_run == TRAS || low_run >= SR_HOLD));

   a_r8_no_forbidden: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dram_ras_n) && $past(busy)) |-> !(low_run >= SR_FORBID && low_run < SR_HOLD));

   a_r8_sr_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      status[1] |-> (busy && !dram_ras_n && !dram_ucas_n && !dram_lcas_n));

   a_r5_sweep_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[1]) |-> !status[0]);

   a_r6_entry_needs_sweep: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[1]) |-> $past(status[0]));
endmodule

bind refresh_sched refresh_sched_chk #(
   .TRAS(TRAS), .SR_FORBID(SR_FORBID), .SR_HOLD(SR_HOLD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_gnt(ref_gnt),
   .busy(busy), .dram_ras_n(dram_ras_n), .dram_ucas_n(dram_ucas_n),
   .dram_lcas_n(dram_lcas_n), .status(status)
);

// File: tb/tb_refresh_sched.sv
`timescale 1ns/1ps
module tb_refresh_sched;
   localparam int INTERVAL  = 40;
   localparam int ROWS      = 8;
   localparam int TCSR      = 1;
   localparam int TRAS      = 3;
   localparam int TRP       = 2;
   localparam int SR_FORBID = 20;
   localparam int SR_HOLD   = 60;
   localparam int TRPS      = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic seq_ras_n = 1'b1, seq_ucas_n = 1'b1, seq_lcas_n = 1'b1;
   logic ref_gnt = 1'b0, lp_req = 1'b0, wake_req = 1'b0;
   logic ref_req, busy, dram_ras_n, dram_ucas_n, dram_lcas_n;
   logic [1:0] status;

   int checks = 0, failures = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   refresh_sched #(
      .INTERVAL(INTERVAL), .ROWS(ROWS), .TCSR(TCSR), .TRAS(TRAS), .TRP(TRP),
      .SR_FORBID(SR_FORBID), .SR_HOLD(SR_HOLD), .TRPS(TRPS)
   ) dut (
      .clk(clk), .rst_n(rst_n), .seq_ras_n(seq_ras_n), .seq_ucas_n(seq_ucas_n),
      .seq_lcas_n(seq_lcas_n), .ref_gnt(ref_gnt), .lp_req(lp_req),
      .wake_req(wake_req), .ref_req(ref_req), .busy(busy),
      .dram_ras_n(dram_ras_n), .dram_ucas_n(dram_ucas_n),
      .dram_lcas_n(dram_lcas_n), .status(status)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // ---------------- cycle monitor (negedge sampling) ----------------
   bit mon_on = 0;
   int cyc = 0, low_len = 0, high_len = 1000, cas_len = 0, pre_high = 0;
   int prev_low = 0, model_sweep = 0, last_fall = -1, sr_count = 0, first_sr_len = 0;
   bit prev_ras = 1, prev_sr = 0, after_sr = 0;

   always @(negedge clk) begin
      cyc++;
      if (mon_on) begin
         if (prev_ras && !dram_ras_n && busy) begin
            check(cas_len >= TCSR, "R3 cas lead", cas_len, TCSR);
            check(high_len >= (after_sr ? TRPS : TRP), "R3 precharge", high_len, TRP);
            if (after_sr)
               check(high_len == TRPS + TCSR, "R9 exit precharge", high_len, TRPS + TCSR);
            else if (last_fall >= 0)
               check(cyc - last_fall <= 2 * INTERVAL, "R4 gap", cyc - last_fall, 2 * INTERVAL);
            last_fall = cyc;
            after_sr = 0;
            pre_high = high_len;
         end
         if (!prev_ras && dram_ras_n && busy) begin
            if (low_len >= SR_HOLD) begin
               check(pre_high == TRP + TCSR && prev_low == TRAS, "R7 entry bracket", pre_high, TRP + TCSR);
               check(status[0] == 1'b0, "R5 sweep clear", status[0], 0);
               if (sr_count == 1) first_sr_len = low_len;
               model_sweep = 0;
               after_sr = 1;
               last_fall = -1;
            end else begin
               check(low_len == TRAS, "R3 ras low", low_len, TRAS);
               model_sweep++;
               check(status[0] == (model_sweep >= ROWS), "R5 sweep flag", status[0], model_sweep >= ROWS);
            end
            check(!(low_len >= SR_FORBID && low_len < SR_HOLD), "R8 forbidden window", low_len, SR_HOLD);
            prev_low = low_len;
         end
         if (status[1] && !prev_sr) begin
            sr_count++;
            check(model_sweep >= ROWS, "R6 entry needs sweep", model_sweep, ROWS);
            check(!dram_ras_n && !dram_ucas_n && !dram_lcas_n && busy, "R8 sr strobes",
                  {dram_ras_n, dram_ucas_n, dram_lcas_n}, 0);
         end
      end
      if (!dram_ucas_n && !dram_lcas_n && dram_ras_n) cas_len++;
      else if (dram_ras_n) cas_len = 0;
      if (!dram_ras_n) begin low_len++; high_len = 0; end
      else begin high_len++; low_len = 0; end
      prev_ras = dram_ras_n;
      prev_sr  = status[1];
   end

   // ---------------- sequencer model: grants after varying delays ----------------
   bit gnt_en = 0;
   initial begin
      int dly;
      dly = 0;
      forever begin
         @(negedge clk);
         if (gnt_en && ref_req) begin
            repeat (dly) @(negedge clk);
            ref_gnt = 1'b1;
            @(negedge clk);
            while (!busy) @(negedge clk);
            ref_gnt = 1'b0;
            dly = (dly + 5) % 17;
         end
      end
   end

   task automatic wait_sr(input bit level, input string req);
      int n;
      n = 0;
      while (status[1] != level && n < 5000) begin @(negedge clk); n++; end
      check(status[1] == level, req, status[1], level);
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 / R5 reset state and pass-through
      check(busy == 0 && ref_req == 0, "R1 reset idle", {busy, ref_req}, 0);
      check(status == 2'b00, "R5 reset status", status, 0);
      seq_ras_n = 1'b0; seq_ucas_n = 1'b0; #0.1;
      check(dram_ras_n == 0 && dram_ucas_n == 0 && dram_lcas_n == 1, "R1 pass low",
            {dram_ras_n, dram_ucas_n, dram_lcas_n}, 1);
      seq_ras_n = 1'b1; seq_ucas_n = 1'b1; seq_lcas_n = 1'b0; #0.1;
      check(dram_ras_n == 1 && dram_ucas_n == 1 && dram_lcas_n == 0, "R1 pass high",
            {dram_ras_n, dram_ucas_n, dram_lcas_n}, 6);
      seq_lcas_n = 1'b1;
      mon_on = 1;
      // R2 first request timing
      n = 1;
      while (!ref_req && n < 200) begin @(negedge clk); n++; end
      check(n >= INTERVAL - 1 && n <= INTERVAL + 1, "R2 first request", n, INTERVAL);
      repeat (20) @(negedge clk);
      check(ref_req == 1 && busy == 0, "R2 pending held", {ref_req, busy}, 2);
      // R6: low-power asked before any sweep
      lp_req = 1'b1;
      gnt_en = 1;
      wait_sr(1'b1, "R8 first entry");
      wake_req = 1'b1;
      wait_sr(1'b0, "R9 first exit");
      wake_req = 1'b0;
      @(negedge clk);
      check(first_sr_len == SR_HOLD, "R8 hold with early wake", first_sr_len, SR_HOLD);
      check(busy == 1, "R9 busy through exit", busy, 1);
      n = 0;
      while (busy && n < 100) begin @(negedge clk); n++; end
      check(busy == 0 && model_sweep == 1, "R9 post-exit refresh", model_sweep, 1);
      // R6 re-entry only after a new sweep
      wait_sr(1'b1, "R6 second entry");
      repeat (100) @(negedge clk);
      check(status[1] == 1, "R8 stays in self-refresh", status[1], 1);
      wake_req = 1'b1;
      wait_sr(1'b0, "R9 second exit");
      wake_req = 1'b0;
      lp_req = 1'b0;
      repeat (12 * INTERVAL) @(negedge clk);
      check(sr_count == 2 && status[1] == 0, "R6 no entry without lp_req", sr_count, 2);
      check(status[0] == 1 && model_sweep >= ROWS, "R5 sweep after exit", model_sweep, ROWS);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      finish_run();
   end
endmodule